// File: doc/BRIEF.md
# PWM Ramp Edge Timing Generator

This block converts a per-cycle duty command into the two edge times of a digital pulse-width ramp cycle and drives the pulse output from a free-running ramp counter. The counter runs in 5 ns ticks over the switching period, or over half the period when bridge mode is selected. The first edge time (`t1_o`) switches the output on, and the second (`t2_o`) switches it off.

Three modulation schemes place the pulse inside the cycle. Trailing-edge mode anchors the pulse at the start of the cycle. Leading-edge mode anchors it at the end. Dual-edge mode centres it. Three independent overrides act at different points: a forced duty replaces the duty command before the on-time is computed, and a forced t1 or a forced t2 replaces the final edge time. A minimum pulse width stretches short, nonzero pulses. All inputs are sampled only when the counter wraps, so the edges never move in the middle of a cycle.

Top module: `pwm_edge_gen`

## Requirements
- R1: While `rst_n` is low, `t1_o` and `t2_o` are 0 and `pwm_o` is low.
- R2: The cycle span S is `period_i` when `bridge_i` is 0 and `period_i >> 1` when it is 1. The counter steps 0, 1, …, S−1 and then returns to 0. A span of 0 or 1 makes the counter wrap on every clock.
- R3: Period, bridge, mode, duty, force values and their enables, and minimum width are sampled only on the clock edge where the counter wraps. On every other edge, `t1_o` and `t2_o` hold their values.
- R4: `mode_i` = 0 (trailing) or 3: `t1_o` = 0 and `t2_o` = on, where on = (S × duty) >> 8.
- R5: `mode_i` = 1 (leading): `t2_o` = S and `t1_o` = S − on.
- R6: `mode_i` = 2 (dual): `t1_o` = (S − on) >> 1 and `t2_o` = `t1_o` + on.
- R7: When `force_duty_en_i` is 1, `force_duty_i` replaces `duty_i` as the duty. When it is 0, `duty_i` is used.
- R8: A nonzero on-time shorter than `min_pw_i` is raised to `min_pw_i`. The on-time is then capped at S. A computed on-time of 0 stays 0, so no pulse is produced.
- R9: `force_t1_en_i` = 1 replaces the computed t1 with `force_t1_i`, and `force_t2_en_i` = 1 replaces the computed t2 with `force_t2_i`. Each enable acts independently of the other.
- R10: `pwm_o` is high exactly when `t1_o` ≤ counter < `t2_o`. It therefore stays low for the whole cycle when `t1_o` ≥ `t2_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Ramp tick clock (5 ns) |
| rst_n | input | 1 | Active-low synchronous reset |
| period_i | input | 11 | Switching period in ticks |
| bridge_i | input | 1 | 1 halves the cycle span |
| mode_i | input | 2 | 0 trailing, 1 leading, 2 dual, 3 trailing |
| duty_i | input | 8 | Computed duty, LSB = 1/256 of span |
| force_duty_en_i | input | 1 | Selects the forced duty |
| force_duty_i | input | 8 | Forced duty value |
| force_t1_en_i | input | 1 | Selects the forced first edge |
| force_t1_i | input | 11 | Forced first edge time |
| force_t2_en_i | input | 1 | Selects the forced second edge |
| force_t2_i | input | 11 | Forced second edge time |
| min_pw_i | input | 8 | Minimum pulse width in ticks |
| t1_o | output | 11 | Active first edge time |
| t2_o | output | 11 | Active second edge time |
| pwm_o | output | 1 | Pulse output |

## Verification
The bench changes the duty in the middle of a cycle. A design that reloaded its edges continuously would then show a glitching pulse width. Tiny duties are run with a large minimum width: one duty rounds to zero on-time and must give no pulse, and another must be stretched. A minimum width larger than the span must be capped, or the pulse would run past the end of the cycle. A forced t1 placed beyond a forced t2 must keep the output low, where a design that compared edges loosely would emit a pulse. Bridge mode and a near-full duty at a long period check that span halving and the wide multiplication keep their upper bits.

// File: rtl/pwm_edge_pkg.sv
package pwm_edge_pkg;
    localparam int TW = 11;

    typedef enum logic [1:0] {
        MOD_TRAIL = 2'd0,
        MOD_LEAD  = 2'd1,
        MOD_DUAL  = 2'd2,
        MOD_ALT   = 2'd3
    } mod_e;

    typedef struct packed {
        logic [TW-1:0] cnt;
        logic [TW-1:0] span;
        logic [TW-1:0] t1;
        logic [TW-1:0] t2;
    } ramp_st_t;
endpackage

// File: rtl/pwm_edge_calc.sv
module pwm_edge_calc #(
    parameter int TW = 11,
    parameter int DW = 8,
    parameter int MW = 8
) (
    input  logic [TW-1:0] span,
    input  logic [1:0]    mode,
    input  logic [DW-1:0] duty_c,
    input  logic          fduty_en,
    input  logic [DW-1:0] duty_f,
    input  logic [MW-1:0] min_pw,
    input  logic          ft1_en,
    input  logic [TW-1:0] ft1,
    input  logic          ft2_en,
    input  logic [TW-1:0] ft2,
    output logic [TW-1:0] t1,
    output logic [TW-1:0] t2
);
    import pwm_edge_pkg::*;

    localparam int PW = TW + DW;

    logic [DW-1:0] duty_sel;
    logic [PW-1:0] prod;
    logic [TW-1:0] on_raw;
    logic [TW-1:0] on_len;
    logic [TW-1:0] e1, e2;

    always_comb begin
        duty_sel = fduty_en ? duty_f : duty_c;
        prod     = PW'(span) * PW'(duty_sel);
        on_raw   = TW'(prod >> DW);
        on_len   = on_raw;
        if ((on_raw != '0) && (on_raw < TW'(min_pw)))
            on_len = TW'(min_pw);
        if (on_len > span)
            on_len = span;

        case (mod_e'(mode))
            MOD_LEAD: begin
                e1 = span - on_len;
                e2 = span;
            end
            MOD_DUAL: begin
                e1 = (span - on_len) >> 1;
                e2 = ((span - on_len) >> 1) + on_len;
            end
            default: begin
                e1 = '0;
                e2 = on_len;
            end
        endcase

        t1 = ft1_en ? ft1 : e1;
        t2 = ft2_en ? ft2 : e2;
    end
endmodule

// File: rtl/pwm_edge_gen.sv
module pwm_edge_gen #(
    parameter int TW = 11,
    parameter int DW = 8,
    parameter int MW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] period_i,
    input  logic          bridge_i,
    input  logic [1:0]    mode_i,
    input  logic [DW-1:0] duty_i,
    input  logic          force_duty_en_i,
    input  logic [DW-1:0] force_duty_i,
    input  logic          force_t1_en_i,
    input  logic [TW-1:0] force_t1_i,
    input  logic          force_t2_en_i,
    input  logic [TW-1:0] force_t2_i,
    input  logic [MW-1:0] min_pw_i,
    output logic [TW-1:0] t1_o,
    output logic [TW-1:0] t2_o,
    output logic          pwm_o
);
    import pwm_edge_pkg::*;

    typedef struct packed {
        logic [TW-1:0] cnt;
        logic [TW-1:0] span;
        logic [TW-1:0] t1;
        logic [TW-1:0] t2;
    } st_t;

    st_t st_d, st_q;

    logic [TW-1:0] span_next;
    logic [TW-1:0] t1_calc, t2_calc;
    logic [TW-1:0] cnt_q, span_q;
    logic          wrap;

    assign cnt_q     = st_q.cnt;
    assign span_q    = st_q.span;
    assign span_next = bridge_i ? (period_i >> 1) : period_i;
    assign wrap      = (span_q == '0) || (cnt_q >= span_q - TW'(1));

    pwm_edge_calc #(.TW(TW), .DW(DW), .MW(MW)) u_calc (
        .span     (span_next),
        .mode     (mode_i),
        .duty_c   (duty_i),
        .fduty_en (force_duty_en_i),
        .duty_f   (force_duty_i),
        .min_pw   (min_pw_i),
        .ft1_en   (force_t1_en_i),
        .ft1      (force_t1_i),
        .ft2_en   (force_t2_en_i),
        .ft2      (force_t2_i),
        .t1       (t1_calc),
        .t2       (t2_calc)
    );

    always_comb begin
        st_d = st_q;
        if (wrap) begin
            st_d.cnt  = '0;
            st_d.span = span_next;
            st_d.t1   = t1_calc;
            st_d.t2   = t2_calc;
        end else begin
            st_d.cnt  = st_q.cnt + TW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign t1_o  = st_q.t1;
    assign t2_o  = st_q.t2;
    assign pwm_o = (cnt_q >= st_q.t1) && (cnt_q < st_q.t2);
endmodule

// File: rtl/pwm_edge_chk.sv
module pwm_edge_chk #(
    parameter int TW = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic [TW-1:0] period_i,
    input logic          bridge_i,
    input logic [1:0]    mode_i,
    input logic          force_t1_en_i,
    input logic [TW-1:0] force_t1_i,
    input logic          force_t2_en_i,
    input logic [TW-1:0] t1_o,
    input logic [TW-1:0] t2_o,
    input logic [TW-1:0] cnt_q,
    input logic [TW-1:0] span_q,
    input logic          wrap
);
    p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (span_q != '0) |-> (cnt_q < span_q));

    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> (cnt_q == $past(cnt_q) + TW'(1)));

    p_edges_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> ($stable(t1_o) && $stable(t2_o)));

    p_trail_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && (mode_i == 2'd0) && !force_t1_en_i) |=> (t1_o == '0));

    p_lead_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && (mode_i == 2'd1) && !force_t2_en_i)
        |=> (t2_o == $past(bridge_i ? (period_i >> 1) : period_i)));

    p_edge_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !force_t1_en_i && !force_t2_en_i) |=> (t1_o <= t2_o));

    p_force_t1_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && force_t1_en_i) |=> (t1_o == $past(force_t1_i)));
endmodule

bind pwm_edge_gen pwm_edge_chk #(.TW(TW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .period_i      (period_i),
    .bridge_i      (bridge_i),
    .mode_i        (mode_i),
    .force_t1_en_i (force_t1_en_i),
    .force_t1_i    (force_t1_i),
    .force_t2_en_i (force_t2_en_i),
    .t1_o          (t1_o),
    .t2_o          (t2_o),
    .cnt_q         (cnt_q),
    .span_q        (span_q),
    .wrap          (wrap)
);

// File: tb/test_pwm_edge_gen.sv
`timescale 1ns/1ps
module test_pwm_edge_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] period_i = 11'd40;
    logic        bridge_i = 1'b0;
    logic [1:0]  mode_i = 2'd0;
    logic [7:0]  duty_i = 8'd0;
    logic        force_duty_en_i = 1'b0;
    logic [7:0]  force_duty_i = 8'd0;
    logic        force_t1_en_i = 1'b0;
    logic [10:0] force_t1_i = 11'd0;
    logic        force_t2_en_i = 1'b0;
    logic [10:0] force_t2_i = 11'd0;
    logic [7:0]  min_pw_i = 8'd0;
    logic [10:0] t1_o, t2_o;
    logic        pwm_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    string tag = "R1";

    int m_cnt = 0, m_span = 0, m_t1 = 0, m_t2 = 0;

    always #2.5 clk = ~clk;

    pwm_edge_gen i_pwm_edge_gen (
        .clk(clk), .rst_n(rst_n), .period_i(period_i), .bridge_i(bridge_i),
        .mode_i(mode_i), .duty_i(duty_i), .force_duty_en_i(force_duty_en_i),
        .force_duty_i(force_duty_i), .force_t1_en_i(force_t1_en_i),
        .force_t1_i(force_t1_i), .force_t2_en_i(force_t2_en_i),
        .force_t2_i(force_t2_i), .min_pw_i(min_pw_i),
        .t1_o(t1_o), .t2_o(t2_o), .pwm_o(pwm_o)
    );

    // behavioural reference of one ramp cycle
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_span = 0; m_t1 = 0; m_t2 = 0;
        end else if (m_span == 0 || m_cnt >= m_span - 1) begin
            int s, d, on;
            s  = bridge_i ? int'(period_i) / 2 : int'(period_i);
            d  = force_duty_en_i ? int'(force_duty_i) : int'(duty_i);
            on = (s * d) / 256;
            if (on > 0 && on < int'(min_pw_i)) on = int'(min_pw_i);
            if (on > s) on = s;
            case (mode_i)
                2'd1:    begin m_t1 = s - on;       m_t2 = s; end
                2'd2:    begin m_t1 = (s - on) / 2; m_t2 = m_t1 + on; end
                default: begin m_t1 = 0;            m_t2 = on; end
            endcase
            if (force_t1_en_i) m_t1 = int'(force_t1_i);
            if (force_t2_en_i) m_t2 = int'(force_t2_i);
            m_cnt = 0;
            m_span = s;
        end else begin
            m_cnt = m_cnt + 1;
        end
    end

    task automatic check(input string r, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
        end
    endtask

    task automatic compare_now();
        check(tag, "t1", int'(t1_o), m_t1);
        check(tag, "t2", int'(t2_o), m_t2);
        check(tag, "pwm", int'(pwm_o), (m_cnt >= m_t1 && m_cnt < m_t2) ? 1 : 0);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare_now();
        end
    endtask

    initial begin
        // R1: reset values
        repeat (3) @(negedge clk);
        check("R1", "t1 in reset", int'(t1_o), 0);
        check("R1", "t2 in reset", int'(t2_o), 0);
        check("R1", "pwm in reset", int'(pwm_o), 0);
        rst_n = 1'b1;

        // R4: trailing edge, period 40, duty 64 -> on 10
        tag = "R4"; mode_i = 2'd0; duty_i = 8'd64;
        run(100);
        check("R4", "t2 value", int'(t2_o), 10);
        mode_i = 2'd3; run(90);

        // R5: leading edge, duty 128 -> t1 20, t2 40
        tag = "R5"; mode_i = 2'd1; duty_i = 8'd128;
        run(90);
        check("R5", "t1 value", int'(t1_o), 20);

        // R6: dual edge, period 41 duty 64 -> on 10, t1 15, t2 25
        tag = "R6"; mode_i = 2'd2; period_i = 11'd41; duty_i = 8'd64;
        run(100);
        check("R6", "t1 value", int'(t1_o), 15);
        check("R6", "t2 value", int'(t2_o), 25);

        // R2: bridge halves the span
        tag = "R2"; period_i = 11'd80; bridge_i = 1'b1; mode_i = 2'd1;
        run(100);
        check("R2", "t2 = half period", int'(t2_o), 40);
        bridge_i = 1'b0; period_i = 11'd1; run(10);
        period_i = 11'd40; run(50);

        // R3: duty change in mid-cycle must not move edges
        tag = "R3"; mode_i = 2'd0; duty_i = 8'd64;
        run(50);
        while (m_cnt != 5) begin @(negedge clk); compare_now(); end
        begin
            int h1, h2;
            h1 = int'(t1_o); h2 = int'(t2_o);
            duty_i = 8'd200; period_i = 11'd60; mode_i = 2'd1;
            @(negedge clk); compare_now();
            check("R3", "t1 held mid-cycle", int'(t1_o), h1);
            check("R3", "t2 held mid-cycle", int'(t2_o), h2);
        end
        run(150);

        // R7: forced duty selects 32 over 200, trailing, period 40 -> on 5
        tag = "R7"; period_i = 11'd40; mode_i = 2'd0;
        force_duty_en_i = 1'b1; force_duty_i = 8'd32;
        run(90);
        check("R7", "forced on-time", int'(t2_o), 5);
        force_duty_en_i = 1'b0; run(90);

        // R8: minimum width; duty 2 -> zero, duty 13 -> 2 raised to 7, cap at span
        tag = "R8"; min_pw_i = 8'd7; duty_i = 8'd2;
        run(90);
        check("R8", "zero duty gives no pulse", int'(t2_o), 0);
        duty_i = 8'd13; run(90);
        check("R8", "stretched width", int'(t2_o), 7);
        min_pw_i = 8'd200; mode_i = 2'd2; run(90);
        check("R8", "width capped to span", int'(t2_o) - int'(t1_o), 40);
        min_pw_i = 8'd0;

        // R9: independent edge forces
        tag = "R9"; mode_i = 2'd0; duty_i = 8'd128;
        force_t2_en_i = 1'b1; force_t2_i = 11'd33;
        run(90);
        check("R9", "forced t2 only", int'(t2_o), 33);
        force_t2_en_i = 1'b0; force_t1_en_i = 1'b1; force_t1_i = 11'd4;
        run(90);
        check("R9", "forced t1 only", int'(t1_o), 4);

        // R10: forced t1 beyond forced t2 keeps output low
        tag = "R10"; force_t1_i = 11'd30; force_t2_en_i = 1'b1; force_t2_i = 11'd10;
        run(90);
        force_t1_en_i = 1'b0; force_t2_en_i = 1'b0;

        // R4: long period, near-full duty -> on 1992
        tag = "R4"; period_i = 11'd2000; duty_i = 8'd255; mode_i = 2'd0;
        run(4100);
        check("R4", "wide on-time", int'(t2_o), 1992);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(100000 * 5);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule